// File: doc/BRIEF.md
# Buck Phase PWM Gate Sequencer

This block holds the digital switching logic of one phase of a multiphase buck converter that uses trailing-edge, voltage-mode control. The analog comparators around it are reduced to synchronous flags: a phase clock, a ramp-crossed-error-level flag, a ramp-near-reference flag, a body-braking flag, sensed gate-low feedback for each power switch, and three fault or mode flags. From these it produces the high-side and low-side gate enables and a control that discharges the PWM ramp.

A falling edge on the phase clock starts an on-time. The low-side gate is released first. The high-side gate turns on only once the low-side gate has been seen low. The on-time ends when the ramp crosses the error level, and the sequence then runs in reverse. Dead time is adaptive, because each gate waits on the sensed state of the other. A non-overlap capture register holds each sensed-low event, so a short glitch on the sense line cannot undo a transition that has already been seen. Four overrides sit on top of the PWM sequence in a fixed priority: debug isolation, overvoltage crowbar, synchronous-rectification block, and body braking.

States: `ST_LS_ON` (low side on, ramp held discharged), `ST_DT_LH` (dead time before the high side, ramp running), `ST_HS_ON` (high side on), `ST_DT_HL` (dead time before the low side, ramp discharging), and `ST_MIN_OFF` (forced off-time at full duty). Transitions:
- ST_LS_ON→ST_DT_LH on a clock fall without a ramp cross.
- ST_DT_LH→ST_HS_ON once the low-side-low capture is set.
- ST_DT_LH→ST_DT_HL on a ramp cross.
- ST_HS_ON→ST_DT_HL on a ramp cross.
- ST_HS_ON→ST_MIN_OFF on a clock fall without a ramp cross.
- ST_DT_HL→ST_LS_ON once the high-side-low capture is set.
- ST_MIN_OFF→ST_DT_HL on a ramp cross.
- ST_MIN_OFF→ST_DT_LH when the ramp is near the reference.

Top module: `buck_gate_seq`

## Requirements
- R1: While reset is held and right after it is released, the outputs are hs_en=0, ls_en=1 and ramp_dis=1 (state ST_LS_ON).
- R2: A clock fall (pwm_clk 1 in the previous cycle and 0 now) in ST_LS_ON, with ramp_above_ea low, clears ls_en and ramp_dis after that edge. hs_en rises one edge after the edge at which ls_low_sense was sampled high. hs_en and ls_en are never high together.
- R3: ramp_above_ea high in ST_HS_ON clears hs_en and sets ramp_dis after that edge. ls_en rises one edge after the edge at which hs_low_sense was sampled high.
- R4: The latch is reset-dominant. A clock fall that arrives in ST_LS_ON together with ramp_above_ea leaves the outputs at hs_en=0, ls_en=1, ramp_dis=1.
- R5: A clock fall in ST_HS_ON, with ramp_above_ea low, forces hs_en low and ramp_dis high. The high side stays off while ramp_near_ref is low. Once ramp_near_ref is high, the block passes through dead time and turns the high side back on.
- R6: ea_below_share high forces ls_en low (body braking).
- R7: sr_block high (output under-voltage with negative current) forces ls_en low.
- R8: ovp_flag high forces ls_en=1 and hs_en=0 for as long as it stays high. The PWM state continues when the flag drops.
- R9: debug_mode high forces hs_en=0 and ls_en=0.
- R10: Override priority, highest first: debug_mode, ovp_flag, then sr_block or ea_below_share, then PWM.
- R11: Once a sensed-low event is captured while the gate is disabled, it holds until that gate is enabled again. A one-cycle sense pulse is enough to advance the dead time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_clk | input | 1 | Phase clock pulse, idle high; the falling edge starts a cycle |
| ramp_above_ea | input | 1 | Ramp above the error-amplifier level |
| ea_below_share | input | 1 | Error level below the share-adjust level (body braking) |
| ramp_near_ref | input | 1 | Ramp within the re-enable band of the reference |
| hs_low_sense | input | 1 | High-side gate sensed low |
| ls_low_sense | input | 1 | Low-side gate sensed low |
| ovp_flag | input | 1 | Overvoltage detected |
| debug_mode | input | 1 | Isolate the phase |
| sr_block | input | 1 | Output under-voltage with negative current |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| ramp_dis | output | 1 | Ramp discharge command |

## Verification
A wrong sequencer state shows at the ports within one cycle. The gate-enable and ramp-discharge triple is unique to each state, except that ST_DT_HL and ST_MIN_OFF share one pattern; those two are told apart by how they leave. A lost or stale non-overlap capture shows up as a dead time that is one cycle too long or too short, or that never ends. The scoreboard compares all three outputs every cycle, so any such error is caught at the first edge where it appears. Override faults are driven in states where the PWM value differs from the forced value, so an override that fails to win is visible.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
    typedef enum logic [2:0] {
        ST_LS_ON   = 3'd0,
        ST_DT_LH   = 3'd1,
        ST_HS_ON   = 3'd2,
        ST_DT_HL   = 3'd3,
        ST_MIN_OFF = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic hs;
        logic ls;
        logic rd;
    } gate_cmd_t;

    localparam int GATE_CNT = 2;
    localparam int GATE_HS  = 0;
    localparam int GATE_LS  = 1;
endpackage

// File: rtl/bgs_clk_edge.sv
module bgs_clk_edge #(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pclk,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= IDLE_LEVEL;
        else        prev_q <= pclk;
    end

    assign fall = prev_q & ~pclk;
endmodule

// File: rtl/bgs_nonoverlap.sv
module bgs_nonoverlap (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_en,
    input  logic sensed_low,
    output logic low_ok
);
    logic cap_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       cap_q <= 1'b0;
        else if (gate_en) cap_q <= 1'b0;
        else if (sensed_low) cap_q <= 1'b1;
    end

    assign low_ok = cap_q;

    // R11
    hold_until_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q && !gate_en) |=> cap_q);
endmodule

// File: rtl/bgs_fsm.sv
module bgs_fsm
    import bgs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clk_fall,
    input  logic      ramp_above,
    input  logic      ramp_near,
    input  logic      hs_ok,
    input  logic      ls_ok,
    output gate_cmd_t cmd
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LS_ON;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LS_ON:   if (clk_fall && !ramp_above) state_d = ST_DT_LH;
            ST_DT_LH:   if (ramp_above)              state_d = ST_DT_HL;
                        else if (ls_ok)              state_d = ST_HS_ON;
            ST_HS_ON:   if (ramp_above)              state_d = ST_DT_HL;
                        else if (clk_fall)           state_d = ST_MIN_OFF;
            ST_DT_HL:   if (hs_ok)                   state_d = ST_LS_ON;
            ST_MIN_OFF: if (ramp_above)              state_d = ST_DT_HL;
                        else if (ramp_near)          state_d = ST_DT_LH;
            default:                                 state_d = ST_LS_ON;
        endcase
    end

    always_comb begin
        cmd = '{hs: 1'b0, ls: 1'b0, rd: 1'b1};
        unique case (state_q)
            ST_LS_ON:   cmd = '{hs: 1'b0, ls: 1'b1, rd: 1'b1};
            ST_DT_LH:   cmd = '{hs: 1'b0, ls: 1'b0, rd: 1'b0};
            ST_HS_ON:   cmd = '{hs: 1'b1, ls: 1'b0, rd: 1'b0};
            ST_DT_HL:   cmd = '{hs: 1'b0, ls: 1'b0, rd: 1'b1};
            ST_MIN_OFF: cmd = '{hs: 1'b0, ls: 1'b0, rd: 1'b1};
            default:    cmd = '{hs: 1'b0, ls: 1'b0, rd: 1'b1};
        endcase
    end

    // R2
    hs_after_ls_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HS_ON && $past(state_q) != ST_HS_ON) |-> $past(ls_ok));
    // R3
    ls_after_hs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LS_ON && $past(state_q) == ST_DT_HL) |-> $past(hs_ok));
    // R4
    reset_dominant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LS_ON && clk_fall && ramp_above) |=> state_q == ST_LS_ON);
    // R5
    min_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MIN_OFF && !ramp_near) |=>
        (state_q == ST_MIN_OFF || state_q == ST_DT_HL));
endmodule

// File: rtl/bgs_override.sv
module bgs_override
    import bgs_pkg::*;
(
    input  gate_cmd_t pwm_cmd,
    input  logic      dbg,
    input  logic      ovp,
    input  logic      sr_blk,
    input  logic      brake,
    output gate_cmd_t out_cmd
);
    always_comb begin
        out_cmd = pwm_cmd;
        if (dbg) begin
            out_cmd.hs = 1'b0;
            out_cmd.ls = 1'b0;
        end else if (ovp) begin
            out_cmd.hs = 1'b0;
            out_cmd.ls = 1'b1;
        end else if (sr_blk || brake) begin
            out_cmd.ls = 1'b0;
        end
    end
endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq
    import bgs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_clk,
    input  logic ramp_above_ea,
    input  logic ea_below_share,
    input  logic ramp_near_ref,
    input  logic hs_low_sense,
    input  logic ls_low_sense,
    input  logic ovp_flag,
    input  logic debug_mode,
    input  logic sr_block,
    output logic hs_en,
    output logic ls_en,
    output logic ramp_dis
);
    logic      clk_fall;
    gate_cmd_t pwm_cmd, drv_cmd;
    logic [GATE_CNT-1:0] gate_en_v, sense_v, ok_v;

    bgs_clk_edge #(.IDLE_LEVEL(1'b1)) u_edge (
        .clk(clk), .rst_n(rst_n), .pclk(pwm_clk), .fall(clk_fall)
    );

    assign gate_en_v[GATE_HS] = drv_cmd.hs;
    assign gate_en_v[GATE_LS] = drv_cmd.ls;
    assign sense_v[GATE_HS]   = hs_low_sense;
    assign sense_v[GATE_LS]   = ls_low_sense;

    for (genvar g = 0; g < GATE_CNT; g++) begin : g_nol
        bgs_nonoverlap u_nol (
            .clk(clk), .rst_n(rst_n), .gate_en(gate_en_v[g]),
            .sensed_low(sense_v[g]), .low_ok(ok_v[g])
        );
    end

    bgs_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .clk_fall(clk_fall),
        .ramp_above(ramp_above_ea), .ramp_near(ramp_near_ref),
        .hs_ok(ok_v[GATE_HS]), .ls_ok(ok_v[GATE_LS]), .cmd(pwm_cmd)
    );

    bgs_override u_ovr (
        .pwm_cmd(pwm_cmd), .dbg(debug_mode), .ovp(ovp_flag),
        .sr_blk(sr_block), .brake(ea_below_share), .out_cmd(drv_cmd)
    );

    assign hs_en    = drv_cmd.hs;
    assign ls_en    = drv_cmd.ls;
    assign ramp_dis = drv_cmd.rd;

    // R2
    no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));
    // R8
    ovp_crowbar_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovp_flag && !debug_mode) |-> (ls_en && !hs_en));
    // R9
    debug_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        debug_mode |-> (!hs_en && !ls_en));
endmodule

// File: tb/buck_gate_seq_tb.sv
module buck_gate_seq_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic  hs;
        logic  ls;
        logic  rd;
        string tag;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic pclk = 1'b1, above = 1'b0, brake = 1'b0, near = 1'b0;
    logic hsl = 1'b1, lsl = 1'b0, ovp = 1'b0, dbg = 1'b0, srd = 1'b0;
    logic hs_en, ls_en, ramp_dis;
    int   n_run = 0, n_fail = 0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    buck_gate_seq u_dut (
        .clk(clk), .rst_n(rst_n), .pwm_clk(pclk), .ramp_above_ea(above),
        .ea_below_share(brake), .ramp_near_ref(near), .hs_low_sense(hsl),
        .ls_low_sense(lsl), .ovp_flag(ovp), .debug_mode(dbg), .sr_block(srd),
        .hs_en(hs_en), .ls_en(ls_en), .ramp_dis(ramp_dis)
    );

    task automatic cmp(input exp_t e);
        n_run++;
        if (hs_en !== e.hs || ls_en !== e.ls || ramp_dis !== e.rd) begin
            n_fail++;
            $display("FAIL %s: got hs=%b ls=%b rd=%b expected hs=%b ls=%b rd=%b",
                     e.tag, hs_en, ls_en, ramp_dis, e.hs, e.ls, e.rd);
        end
    endtask

    // monitor: pops one expected item after each edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) cmp(q.pop_front());
    end

    // driver: inputs {pclk,above,brake,near,hsl,lsl,ovp,dbg,srd}
    task automatic step(input logic [8:0] in, input logic e_hs, input logic e_ls,
                        input logic e_rd, input string tag);
        exp_t e;
        @(negedge clk);
        {pclk, above, brake, near, hsl, lsl, ovp, dbg, srd} = in;
        e.hs = e_hs; e.ls = e_ls; e.rd = e_rd; e.tag = tag;
        q.push_back(e);
        @(posedge clk);
    endtask

    // input shorthand
    function automatic logic [8:0] v(input logic pc, input logic ab, input logic br,
                                     input logic nr, input logic hl, input logic ll,
                                     input logic ov, input logic db, input logic sr);
        return {pc, ab, br, nr, hl, ll, ov, db, sr};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1;
        begin
            exp_t e;
            e.hs = 0; e.ls = 1; e.rd = 1; e.tag = "R1 in reset";
            cmp(e);
        end
        @(negedge clk); rst_n = 1'b1;
        step(v(1,0,0,0,1,0,0,0,0), 0,1,1, "R1 idle");
        // normal cycle with noisy low-side sense
        step(v(0,0,0,0,1,0,0,0,0), 0,0,0, "R2 clock fall");
        step(v(1,0,0,0,1,0,0,0,0), 0,0,0, "R2 waiting ls low");
        step(v(1,0,0,0,1,1,0,0,0), 0,0,0, "R2 ls low captured");
        step(v(1,0,0,0,1,0,0,0,0), 1,0,0, "R11 glitch after capture, hs on");
        step(v(1,0,0,0,0,1,0,0,0), 1,0,0, "R2 hs on");
        step(v(1,1,0,0,0,1,0,0,0), 0,0,1, "R3 ramp cross");
        step(v(1,0,0,0,0,1,0,0,0), 0,0,1, "R3 waiting hs low");
        step(v(1,0,0,0,1,1,0,0,0), 0,0,1, "R3 hs low captured");
        step(v(1,0,0,0,1,1,0,0,0), 0,1,1, "R3 ls on");
        step(v(1,0,0,0,1,0,0,0,0), 0,1,1, "R3 ls steady");
        // reset dominance
        step(v(0,1,0,0,1,0,0,0,0), 0,1,1, "R4 set+reset together");
        step(v(1,0,0,0,1,0,0,0,0), 0,1,1, "R4 still off");
        // full duty
        step(v(0,0,0,0,1,0,0,0,0), 0,0,0, "R2 clock fall");
        step(v(1,0,0,0,1,1,0,0,0), 0,0,0, "R2 ls low");
        step(v(1,0,0,0,1,1,0,0,0), 1,0,0, "R2 hs on");
        step(v(1,0,0,0,0,1,0,0,0), 1,0,0, "R5 hs on");
        step(v(0,0,0,0,0,1,0,0,0), 0,0,1, "R5 forced off");
        step(v(1,0,0,0,1,1,0,0,0), 0,0,1, "R5 hold, ramp not near");
        step(v(1,0,0,1,1,1,0,0,0), 0,0,0, "R5 near ref, dead time");
        step(v(1,0,0,0,1,1,0,0,0), 1,0,0, "R5 hs back on");
        step(v(1,1,0,0,0,1,0,0,0), 0,0,1, "R3 ramp cross");
        step(v(1,0,0,0,1,1,0,0,0), 0,0,1, "R3 hs low");
        step(v(1,0,0,0,1,1,0,0,0), 0,1,1, "R3 ls on");
        // overrides in ST_LS_ON
        step(v(1,0,1,0,1,0,0,0,0), 0,0,1, "R6 body braking");
        step(v(1,0,0,0,1,0,0,0,0), 0,1,1, "R6 release");
        step(v(1,0,0,0,1,0,0,0,1), 0,0,1, "R7 sr block");
        step(v(1,0,0,0,1,0,1,0,1), 0,1,1, "R10 ovp over sr block");
        step(v(1,0,0,0,1,0,0,1,0), 0,0,1, "R9 debug in ls on");
        step(v(1,0,0,0,1,0,0,0,0), 0,1,1, "R9 release");
        // overrides in ST_HS_ON
        step(v(0,0,0,0,1,0,0,0,0), 0,0,0, "R2 clock fall");
        step(v(1,0,0,0,1,1,0,0,0), 0,0,0, "R2 ls low");
        step(v(1,0,0,0,1,1,0,0,0), 1,0,0, "R2 hs on");
        step(v(1,0,0,0,0,1,1,0,0), 0,1,0, "R8 ovp crowbar");
        step(v(1,0,1,0,0,1,1,0,0), 0,1,0, "R10 ovp over braking");
        step(v(1,0,0,0,0,1,1,1,0), 0,0,0, "R10 debug over ovp");
        step(v(1,0,0,0,0,1,0,0,0), 1,0,0, "R8 ovp released, pwm resumes");
        step(v(1,0,1,0,0,1,0,0,0), 1,0,0, "R6 braking leaves hs");
        step(v(1,1,0,0,0,1,0,0,0), 0,0,1, "R3 ramp cross");
        step(v(1,0,0,0,1,1,0,0,0), 0,0,1, "R3 hs low");
        step(v(1,0,0,0,1,1,0,0,0), 0,1,1, "R3 ls on");
        @(posedge clk); #2;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule